// File: doc/BRIEF.md
# Video error-flag access port

This block gives pins direct access to the three groups of error flags carried in the error-detection packet of a serial digital video stream. The groups cover the whole field, the active picture and the ancillary data, and each holds five flags. Upstream checksum logic supplies the flags computed for the current field. The block latches them into packet registers when a field-end strobe arrives. Those registers feed the packet formatter.

A 2-bit select picks which group is shown on a 5-bit flag bus. A direction input sets what the bus does. When it is high, the bus drives the selected group out. When it is low, the bus is an input, and the value on it overrides the selected group's flags in the next packet only.

In map mode the block steps through the groups by itself, one per field, and drives the select lines outward. The pad-side tristate sits outside this block, so every bidirectional pin appears here as an input, an output and an output enable. A saturating counter counts the fields in which any computed flag was set.

Top module: `edh_flag_port`

## Requirements
- R1: Reset clears the three packet flag groups, the errored-field counter and the map-mode select. `sel_o` reads 00 after reset.
- R2: The active select is `sel_i` outside map mode and the internal sequence in map mode. Its codes are 00 full field, 01 active picture, 10 ancillary and 11 idle. `flag_oe` is low whenever the active select is 11.
- R3: When `dir_rd` is high (or map mode is on) and the active select is not 11, `flag_oe` is high in the same cycle. `flag_o` then carries that group's packet flags in the order bit0 EDH, bit1 EDA, bit2 IDH, bit3 IDA, bit4 UES.
- R4: Outside map mode, with `dir_rd` low and a select other than 11, each clock captures `flag_i` as the pending override of the selected group. At the next `field_end` edge, that group's packet flags take the last captured value. A capture in the strobe cycle itself counts.
- R5: An override applies to one packet only. At the following `field_end` with no new write, the group takes the computed flags again.
- R6: A write with select 11 is ignored. No group's packet flags change because of it.
- R7: At a `field_end` edge, each group without a pending override takes its computed input flags. Between strobes, the packet flags do not change.
- R8: At each `field_end` edge where any of the 15 computed input flags is set, `err_cnt` (CNT_W bits, default 24) goes up by one. Otherwise it holds.
- R9: `err_cnt` saturates at all ones and never wraps.
- R10: In map mode, `sel_oe` is high. `sel_o` steps 00, 01, 10, 00 on each `field_end`, and `sel_i` has no effect.
- R11: In map mode, the flag bus is driven out whatever the level of `dir_rd`, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_en | input | 1 | Map mode: block sequences the groups |
| dir_rd | input | 1 | 1 = flag bus drives out, 0 = flag bus accepts overrides |
| field_end | input | 1 | One-cycle field-end strobe |
| sel_i | input | 2 | Group select from the pins |
| sel_o | output | 2 | Group select driven in map mode |
| sel_oe | output | 1 | Output enable for the select pins |
| flag_i | input | 5 | Flag bus value from the pins |
| flag_o | output | 5 | Flag bus value to the pins |
| flag_oe | output | 1 | Output enable for the flag bus |
| ff_in | input | 5 | Computed full-field flags |
| ap_in | input | 5 | Computed active-picture flags |
| anc_in | input | 5 | Computed ancillary flags |
| ff_pkt | output | 5 | Full-field flags for the outgoing packet |
| ap_pkt | output | 5 | Active-picture flags for the outgoing packet |
| anc_pkt | output | 5 | Ancillary flags for the outgoing packet |
| err_cnt | output | CNT_W | Errored-field count |

## Verification
The bus outputs `flag_o` and `flag_oe` are combinational from the select, the direction and the packet registers, so they are due in the same cycle as their stimulus. The packet groups, the counter and the map-mode select change only at the clock edge where `field_end` is high, and they are due right after that edge. The bench drives inputs on the falling edge and compares every output with a behavioural model one time unit later. It then advances the model at the rising edge, so each result is checked exactly one edge after the stimulus that caused it.

// File: rtl/edh_flag_port.sv
module edh_flag_port #(
  parameter int FLAG_W = 5,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_en,
  input  logic              dir_rd,
  input  logic              field_end,
  input  logic [1:0]        sel_i,
  output logic [1:0]        sel_o,
  output logic              sel_oe,
  input  logic [FLAG_W-1:0] flag_i,
  output logic [FLAG_W-1:0] flag_o,
  output logic              flag_oe,
  input  logic [FLAG_W-1:0] ff_in,
  input  logic [FLAG_W-1:0] ap_in,
  input  logic [FLAG_W-1:0] anc_in,
  output logic [FLAG_W-1:0] ff_pkt,
  output logic [FLAG_W-1:0] ap_pkt,
  output logic [FLAG_W-1:0] anc_pkt,
  output logic [CNT_W-1:0]  err_cnt
);
  localparam int         NGRP    = 3;
  localparam logic [1:0] IDLE    = 2'd3;
  localparam logic [1:0] LAST    = 2'(NGRP - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [FLAG_W-1:0] calc    [NGRP];
  logic [FLAG_W-1:0] pkt     [NGRP];
  logic [FLAG_W-1:0] ovr_val [NGRP];
  logic              ovr_v   [NGRP];
  logic [1:0]        map_sel;

  assign calc[0] = ff_in;
  assign calc[1] = ap_in;
  assign calc[2] = anc_in;

  wire [1:0] act_sel = map_en ? map_sel : sel_i;
  wire       wr_en   = !map_en && !dir_rd && (sel_i != IDLE);
  wire       any_err = |{ff_in, ap_in, anc_in};

  assign flag_oe = (map_en || dir_rd) && (act_sel != IDLE);
  assign sel_o   = map_sel;
  assign sel_oe  = map_en;

  always_comb begin
    case (act_sel)
      2'd0:    flag_o = pkt[0];
      2'd1:    flag_o = pkt[1];
      2'd2:    flag_o = pkt[2];
      default: flag_o = '0;
    endcase
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    wire hit = wr_en && (sel_i == 2'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pkt[g]     <= '0;
        ovr_val[g] <= '0;
        ovr_v[g]   <= 1'b0;
      end else if (field_end) begin
        pkt[g]   <= hit ? flag_i : (ovr_v[g] ? ovr_val[g] : calc[g]);
        ovr_v[g] <= 1'b0;
      end else if (hit) begin
        ovr_val[g] <= flag_i;
        ovr_v[g]   <= 1'b1;
      end
    end
  end

  assign ff_pkt  = pkt[0];
  assign ap_pkt  = pkt[1];
  assign anc_pkt = pkt[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt <= '0;
      map_sel <= 2'd0;
    end else if (field_end) begin
      if (any_err && err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
      if (map_en) map_sel <= (map_sel == LAST) ? 2'd0 : map_sel + 2'd1;
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_en && sel_i == IDLE) |-> !flag_oe);
  a_r4_ovr_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !map_en && !dir_rd && sel_i == 2'd0) |=> ff_pkt == $past(flag_i));
  a_r7_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> ($stable(ff_pkt) && $stable(ap_pkt) && $stable(anc_pkt)));
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> $stable(err_cnt));
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == CNT_MAX) |=> (err_cnt == CNT_MAX));
  a_r10_map_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (map_en && field_end && sel_o == LAST) |=> sel_o == 2'd0);
  a_r10_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o != IDLE);
endmodule

// File: tb/sim_edh_flag_port.sv
`timescale 1ns/1ps
module sim_edh_flag_port;
  localparam int CW = 4;
  logic clk = 0, rst_n = 0, map_en = 0, dir_rd = 1, field_end = 0;
  logic [1:0] sel_i = 0, sel_o;
  logic sel_oe, flag_oe;
  logic [4:0] flag_i = 0, flag_o, ff_in = 0, ap_in = 0, anc_in = 0;
  logic [4:0] ff_pkt, ap_pkt, anc_pkt;
  logic [CW-1:0] err_cnt;
  int n_run = 0, n_fail = 0;
  string tag = "R1";

  int m_pkt[3], m_ov[3], m_ovv[3], m_cnt = 0, m_msel = 0;

  always #2.5 clk = ~clk;

  edh_flag_port #(.FLAG_W(5), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .dir_rd(dir_rd), .field_end(field_end),
    .sel_i(sel_i), .sel_o(sel_o), .sel_oe(sel_oe), .flag_i(flag_i), .flag_o(flag_o),
    .flag_oe(flag_oe), .ff_in(ff_in), .ap_in(ap_in), .anc_in(anc_in),
    .ff_pkt(ff_pkt), .ap_pkt(ap_pkt), .anc_pkt(anc_pkt), .err_cnt(err_cnt));

  task automatic chk(string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int calc(int g);
    return g == 0 ? int'(ff_in) : g == 1 ? int'(ap_in) : int'(anc_in);
  endfunction

  task automatic compare();
    int act, eoe, eo;
    act = map_en ? m_msel : int'(sel_i);
    eoe = ((map_en || dir_rd) && act != 3) ? 1 : 0;
    eo  = act != 3 ? m_pkt[act] : 0;
    chk("flag_oe (R2)", int'(flag_oe), eoe);
    if (eoe == 1) chk("flag_o (R3)", int'(flag_o), eo);
    chk("ff_pkt (R7)", int'(ff_pkt), m_pkt[0]);
    chk("ap_pkt (R7)", int'(ap_pkt), m_pkt[1]);
    chk("anc_pkt (R7)", int'(anc_pkt), m_pkt[2]);
    chk("err_cnt (R8)", int'(err_cnt), m_cnt);
    chk("sel_o (R10)", int'(sel_o), m_msel);
    chk("sel_oe (R10)", int'(sel_oe), int'(map_en));
  endtask

  task automatic model_edge();
    bit wr;
    int any;
    wr = !map_en && !dir_rd && sel_i != 3;
    if (field_end) begin
      any = (ff_in | ap_in | anc_in) != 0;
      for (int g = 0; g < 3; g++) begin
        m_pkt[g] = (wr && int'(sel_i) == g) ? int'(flag_i) : (m_ov[g] != 0 ? m_ovv[g] : calc(g));
        m_ov[g] = 0;
      end
      if (any != 0 && m_cnt < (1 << CW) - 1) m_cnt++;
      if (map_en) m_msel = (m_msel == 2) ? 0 : m_msel + 1;
    end else if (wr) begin
      m_ov[sel_i] = 1;
      m_ovv[sel_i] = int'(flag_i);
    end
  endtask

  task automatic step(bit me, bit dr, bit fe, int s, int fi, int f0, int f1, int f2);
    @(negedge clk);
    map_en = me; dir_rd = dr; field_end = fe; sel_i = 2'(s); flag_i = 5'(fi);
    ff_in = 5'(f0); ap_in = 5'(f1); anc_in = 5'(f2);
    #1 compare();
    @(posedge clk);
    model_edge();
  endtask

  task automatic rnd_steps(int n, bit me, int dr_mode, int fe_mod, bit errs);
    for (int i = 0; i < n; i++) begin
      int dr;
      dr = dr_mode == 2 ? int'($urandom_range(0, 1)) : dr_mode;
      step(me, 1'(dr), ($urandom_range(0, fe_mod - 1) == 0), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 31)),
           errs ? int'($urandom_range(0, 31)) : 0, errs ? int'($urandom_range(0, 31)) : 0,
           errs ? int'($urandom_range(0, 31)) : 0);
    end
  endtask

  initial begin
    #50000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int g = 0; g < 3; g++) begin m_pkt[g] = 0; m_ov[g] = 0; m_ovv[g] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R1"; #1 compare();
    tag = "R3"; for (int s = 0; s < 4; s++) step(0, 1, 0, s, 0, 0, 0, 0);
    tag = "R7"; step(0, 1, 1, 0, 0, 5, 10, 17); for (int s = 0; s < 4; s++) step(0, 1, 0, s, 0, 0, 0, 0);
    tag = "R4"; step(0, 0, 0, 1, 9, 0, 0, 0); step(0, 0, 0, 1, 22, 0, 0, 0);
    step(0, 1, 0, 1, 0, 0, 0, 0); step(0, 0, 1, 2, 3, 1, 1, 1);
    for (int s = 0; s < 3; s++) step(0, 1, 0, s, 0, 0, 0, 0);
    tag = "R5"; step(0, 1, 1, 0, 0, 4, 4, 4); for (int s = 0; s < 3; s++) step(0, 1, 0, s, 0, 0, 0, 0);
    tag = "R6"; step(0, 0, 0, 3, 31, 0, 0, 0); step(0, 1, 1, 3, 31, 0, 0, 0);
    for (int s = 0; s < 3; s++) step(0, 1, 0, s, 0, 0, 0, 0);
    tag = "R8"; rnd_steps(40, 0, 1, 4, 0); step(0, 1, 1, 0, 0, 0, 0, 2); step(0, 1, 0, 0, 0, 0, 0, 0);
    tag = "R9"; for (int i = 0; i < 20; i++) step(0, 1, 1, i % 4, 0, 16, 0, 0); step(0, 1, 0, 0, 0, 0, 0, 0);
    tag = "R10"; for (int i = 0; i < 8; i++) step(1, 1, 1, 3 - (i % 4), 0, i, i + 1, i + 2);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    tag = "R11"; rnd_steps(60, 1, 0, 3, 1);
    tag = "R2"; rnd_steps(400, 0, 2, 5, 1);
    tag = "R4"; rnd_steps(400, 0, 0, 6, 1);
    tag = "R11"; rnd_steps(200, 1, 2, 4, 1);
    tag = "R1"; @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    for (int g = 0; g < 3; g++) begin m_pkt[g] = 0; m_ov[g] = 0; end
    m_cnt = 0; m_msel = 0; map_en = 0; dir_rd = 1; #1 compare();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule